// File: doc/BRIEF.md
# Halfword-Granular DMA Alignment Buffer

This block sits between a 16-bit device-side data stream and a 64-bit memory port. Memory is only ever touched in whole, 8-byte-aligned blocks. A 64-bit staging register, visible to software as two 32-bit halves, and a 2-bit chunk pointer counted in halfwords absorb the misalignment at the head and tail of a transfer.

For a device-to-memory transfer, software loads the staging register with the existing memory block that holds the first byte, then starts the transfer. Incoming halfwords fill the staging register from the start chunk upward, and each completed block is written to memory. The preloaded chunks below the start chunk go out unchanged. When the device stops, a partial tail stays in the staging register for software to finish writing. The pointer gives the number of valid chunks and the block address names the block still owed.

For a memory-to-device transfer with an unaligned start, software preloads the first block and the block drains it from the start chunk. Later blocks are fetched from memory one at a time. The tail needs no special handling, because the device side stops the stream.

Top module: `hw_align_buf`

## Requirements
- R1: Every memory write and every memory read request carries an address whose bits 2:0 are zero, and moves one whole 64-bit block.
- R2: The staging register is the concatenation {stage_hi, stage_lo}. Halfword chunk k occupies bits 16k+15:16k, so chunks 0 and 1 are in stage_lo and chunks 2 and 3 are in stage_hi. Software writes each half through sw_wr_lo or sw_wr_hi while the block is idle.
- R3: A device-to-memory start (start_to_dev=0) sets blk_addr to start_addr with bits 2:0 cleared and chunk_ptr to start_addr[2:1], and raises busy one cycle later.
- R4: In a device-to-memory transfer, each cycle with in_valid writes in_data into chunk chunk_ptr and advances the pointer. Filling chunk 3 produces, one cycle later, a single mem_wr_valid pulse carrying the full block at the current blk_addr. blk_addr then advances by 8 and the pointer wraps to 0.
- R5: In the first block written, the preloaded chunks below the start chunk appear unchanged.
- R6: A stop pulse drops busy and raises done in the next cycle. A partial tail is not written to memory. chunk_ptr holds the count of valid chunks, blk_addr names the block owed, and the staging register keeps the tail. These values hold until the next start.
- R7: A memory-to-device start (start_to_dev=1) with start_addr[2:1] nonzero presents the preloaded chunk start_addr[2:1] on out_data with out_valid high the next cycle, and sets blk_addr to the next 8-byte boundary. With start_addr[2:1] zero, it sets blk_addr to start_addr and fetches the block first.
- R8: In a memory-to-device transfer, once chunk 3 has been taken (out_valid and out_ready), out_valid is low. One cycle later a single mem_rd_req pulse is issued at blk_addr. The mem_rd_valid response loads the block, blk_addr advances by 8, and out_data shows chunk 0 the next cycle.
- R9: Staging writes from software while busy are ignored, and a start while busy is ignored.
- R10: in_valid has no effect while idle or during a memory-to-device transfer, and no memory write happens then. busy and done are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_wr_lo | input | 1 | Software write of the low staging half |
| sw_wr_hi | input | 1 | Software write of the high staging half |
| sw_wdata | input | 32 | Software write data |
| start | input | 1 | Start pulse |
| start_to_dev | input | 1 | 1 = memory to device, 0 = device to memory |
| start_addr | input | ADDR_W | Byte start address (even) |
| stop | input | 1 | End of the transfer, from the device side |
| stage_lo | output | 32 | Staging chunks 1:0 |
| stage_hi | output | 32 | Staging chunks 3:2 |
| chunk_ptr | output | 2 | Halfword chunk pointer |
| blk_addr | output | ADDR_W | Current block address, 8-byte aligned |
| busy | output | 1 | Transfer running |
| done | output | 1 | Transfer stopped, residue valid |
| in_valid | input | 1 | Device halfword valid |
| in_data | input | 16 | Device halfword |
| out_valid | output | 1 | Halfword available to the device |
| out_data | output | 16 | Halfword to the device |
| out_ready | input | 1 | Device takes out_data |
| mem_wr_valid | output | 1 | Block write pulse |
| mem_wr_addr | output | ADDR_W | Block write address |
| mem_wr_data | output | 64 | Block write data |
| mem_rd_req | output | 1 | Block read request pulse |
| mem_rd_addr | output | ADDR_W | Block read address |
| mem_rd_valid | input | 1 | Read response valid |
| mem_rd_data | input | 64 | Read response block |

## Verification
The bench starts a device-to-memory transfer at chunk 2 and checks the first written block for the two preloaded chunks. A design that merged at the wrong chunk would overwrite preloaded data or misplace the head. It ends that transfer with a three-chunk tail, where a wrong design would flush a partial block or report the wrong count and address. The memory-to-device runs use both an unaligned and an aligned start. These catch a design that drains from the wrong chunk, fetches the already-preloaded block again, or requests the read one cycle early or twice. Staging writes, starts and input halfwords given at the wrong time are sent while busy or idle, and their effect is checked at the ports.

// File: rtl/hwa_pkg.sv
// Shared constants for the halfword alignment buffer.
// Assumes a 16-bit device lane and a 64-bit memory block.
package hwa_pkg;
    localparam int CHUNK_W   = 16;
    localparam int NCHUNK    = 4;
    localparam int BLK_W     = CHUNK_W * NCHUNK;
    localparam int HALF_W    = BLK_W / 2;
    localparam int CPH       = NCHUNK / 2;
    localparam int BLK_BYTES = BLK_W / 8;
    localparam int OFS_W     = $clog2(BLK_BYTES);
    localparam int PTR_W     = $clog2(NCHUNK);
endpackage

// File: rtl/hw_stage_store.sv
// Staging register: one block of NCHUNK halfword lanes.
// Assumes the writers are mutually exclusive by construction in the caller
// (software only while idle); priority is block load, chunk write, software.
module hw_stage_store
    import hwa_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sw_wr_lo,
    input  logic                sw_wr_hi,
    input  logic [HALF_W-1:0]   sw_wdata,
    input  logic                chunk_we,
    input  logic [PTR_W-1:0]    chunk_sel,
    input  logic [CHUNK_W-1:0]  chunk_data,
    input  logic                blk_we,
    input  logic [BLK_W-1:0]    blk_data,
    output logic [BLK_W-1:0]    stage_q,
    output logic [BLK_W-1:0]    stage_d
);
    logic sw_we_half [2];
    assign sw_we_half[0] = sw_wr_lo;
    assign sw_we_half[1] = sw_wr_hi;

    for (genvar k = 0; k < NCHUNK; k++) begin : g_lane
        localparam int HALF = k / CPH;
        localparam int SUB  = k % CPH;
        // Next value of one halfword lane.
        always_comb begin
            stage_d[k*CHUNK_W +: CHUNK_W] = stage_q[k*CHUNK_W +: CHUNK_W];
            if (blk_we)
                stage_d[k*CHUNK_W +: CHUNK_W] = blk_data[k*CHUNK_W +: CHUNK_W];
            else if (chunk_we && chunk_sel == PTR_W'(k))
                stage_d[k*CHUNK_W +: CHUNK_W] = chunk_data;
            else if (sw_we_half[HALF])
                stage_d[k*CHUNK_W +: CHUNK_W] = sw_wdata[SUB*CHUNK_W +: CHUNK_W];
        end
    end

    // Register the staging block.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end
endmodule

// File: rtl/hw_chunk_seq.sv
// Transfer sequencer: chunk pointer, block address, direction and the
// fill/drain state. Assumes start_addr is even; stop wins over data.
module hw_chunk_seq
    import hwa_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_to_dev,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              stop,
    input  logic              in_valid,
    input  logic              out_ready,
    input  logic              mem_rd_valid,
    output logic              busy,
    output logic              done,
    output logic              to_dev,
    output logic              full,
    output logic [PTR_W-1:0]  ptr,
    output logic [ADDR_W-1:0] blk,
    output logic              chunk_we,
    output logic              wr_fire,
    output logic              rd_fire,
    output logic              blk_we,
    output logic              pop
);
    localparam logic [ADDR_W-1:0] BLK_STEP = ADDR_W'(BLK_BYTES);
    localparam logic [PTR_W-1:0]  LAST     = PTR_W'(NCHUNK - 1);

    logic              pend;
    logic              run;
    logic              take;
    logic [ADDR_W-1:0] start_blk;
    logic [PTR_W-1:0]  start_ptr;

    assign take      = start && !busy;
    assign run       = busy && !stop;
    assign start_blk = {start_addr[ADDR_W-1:OFS_W], OFS_W'(0)};
    assign start_ptr = start_addr[OFS_W-1:1];

    // Strobes for the staging store and the memory port.
    always_comb begin
        chunk_we = run && !to_dev && in_valid;
        wr_fire  = chunk_we && ptr == LAST;
        pop      = run && to_dev && full && out_ready;
        rd_fire  = run && to_dev && !full && !pend;
        blk_we   = run && to_dev && pend && mem_rd_valid;
    end

    // Sequencer state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            to_dev <= 1'b0;
            full   <= 1'b0;
            pend   <= 1'b0;
            ptr    <= '0;
            blk    <= '0;
        end else if (take) begin
            busy   <= 1'b1;
            done   <= 1'b0;
            to_dev <= start_to_dev;
            pend   <= 1'b0;
            ptr    <= start_ptr;
            if (start_to_dev && start_ptr != '0) begin
                blk  <= start_blk + BLK_STEP;
                full <= 1'b1;
            end else begin
                blk  <= start_blk;
                full <= 1'b0;
            end
        end else if (busy && stop) begin
            busy <= 1'b0;
            done <= 1'b1;
            pend <= 1'b0;
        end else if (chunk_we) begin
            ptr <= ptr + 1'b1;
            if (ptr == LAST) blk <= blk + BLK_STEP;
        end else if (pop) begin
            ptr <= ptr + 1'b1;
            if (ptr == LAST) full <= 1'b0;
        end else if (blk_we) begin
            full <= 1'b1;
            pend <= 1'b0;
            ptr  <= '0;
            blk  <= blk + BLK_STEP;
        end else if (rd_fire) begin
            pend <= 1'b1;
        end
    end
endmodule

// File: rtl/hw_align_buf.sv
// Top of the halfword alignment buffer: joins staging store and sequencer,
// registers the memory port strobes, and muxes the outbound halfword.
// Assumes memory accepts every write pulse and read request it is given.
module hw_align_buf
    import hwa_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sw_wr_lo,
    input  logic                sw_wr_hi,
    input  logic [HALF_W-1:0]   sw_wdata,
    input  logic                start,
    input  logic                start_to_dev,
    input  logic [ADDR_W-1:0]   start_addr,
    input  logic                stop,
    output logic [HALF_W-1:0]   stage_lo,
    output logic [HALF_W-1:0]   stage_hi,
    output logic [PTR_W-1:0]    chunk_ptr,
    output logic [ADDR_W-1:0]   blk_addr,
    output logic                busy,
    output logic                done,
    input  logic                in_valid,
    input  logic [CHUNK_W-1:0]  in_data,
    output logic                out_valid,
    output logic [CHUNK_W-1:0]  out_data,
    input  logic                out_ready,
    output logic                mem_wr_valid,
    output logic [ADDR_W-1:0]   mem_wr_addr,
    output logic [BLK_W-1:0]    mem_wr_data,
    output logic                mem_rd_req,
    output logic [ADDR_W-1:0]   mem_rd_addr,
    input  logic                mem_rd_valid,
    input  logic [BLK_W-1:0]    mem_rd_data
);
    logic              to_dev, full;
    logic              chunk_we, wr_fire, rd_fire, blk_we, pop;
    logic [BLK_W-1:0]  stage_q, stage_d;

    hw_chunk_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .start_to_dev (start_to_dev),
        .start_addr   (start_addr),
        .stop         (stop),
        .in_valid     (in_valid),
        .out_ready    (out_ready),
        .mem_rd_valid (mem_rd_valid),
        .busy         (busy),
        .done         (done),
        .to_dev       (to_dev),
        .full         (full),
        .ptr          (chunk_ptr),
        .blk          (blk_addr),
        .chunk_we     (chunk_we),
        .wr_fire      (wr_fire),
        .rd_fire      (rd_fire),
        .blk_we       (blk_we),
        .pop          (pop)
    );

    hw_stage_store u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_wr_lo   (sw_wr_lo && !busy),
        .sw_wr_hi   (sw_wr_hi && !busy),
        .sw_wdata   (sw_wdata),
        .chunk_we   (chunk_we),
        .chunk_sel  (chunk_ptr),
        .chunk_data (in_data),
        .blk_we     (blk_we),
        .blk_data   (mem_rd_data),
        .stage_q    (stage_q),
        .stage_d    (stage_d)
    );

    assign stage_lo  = stage_q[HALF_W-1:0];
    assign stage_hi  = stage_q[BLK_W-1:HALF_W];
    assign out_valid = busy && to_dev && full;
    assign out_data  = stage_q[chunk_ptr*CHUNK_W +: CHUNK_W];

    // Register memory write and read strobes with their address and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_wr_valid <= 1'b0;
            mem_wr_addr  <= '0;
            mem_wr_data  <= '0;
            mem_rd_req   <= 1'b0;
            mem_rd_addr  <= '0;
        end else begin
            mem_wr_valid <= wr_fire;
            mem_rd_req   <= rd_fire;
            if (wr_fire) begin
                mem_wr_addr <= blk_addr;
                mem_wr_data <= stage_d;
            end
            if (rd_fire) mem_rd_addr <= blk_addr;
        end
    end
endmodule

// File: rtl/hw_align_buf_chk.sv
// Property checker for hw_align_buf, attached by bind below.
// Observes ports only; assumes synchronous active-low reset.
module hw_align_buf_chk
    import hwa_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              sw_wr_lo,
    input logic              sw_wr_hi,
    input logic              busy,
    input logic              done,
    input logic [PTR_W-1:0]  chunk_ptr,
    input logic [ADDR_W-1:0] blk_addr,
    input logic [HALF_W-1:0] stage_lo,
    input logic [HALF_W-1:0] stage_hi,
    input logic              mem_wr_valid,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic              mem_rd_req,
    input logic [ADDR_W-1:0] mem_rd_addr
);
    a_r1_wr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> mem_wr_addr[OFS_W-1:0] == '0);
    a_r1_rd_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> mem_rd_addr[OFS_W-1:0] == '0);
    a_r6_residue_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start && !sw_wr_lo && !sw_wr_hi) |=>
        ($stable(chunk_ptr) && $stable(blk_addr) && $stable({stage_hi, stage_lo})));
    a_r10_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    a_r10_wr_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> busy);
    a_r8_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req);
    a_r1_one_port: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_wr_valid, mem_rd_req}));
endmodule

bind hw_align_buf hw_align_buf_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .sw_wr_lo     (sw_wr_lo),
    .sw_wr_hi     (sw_wr_hi),
    .busy         (busy),
    .done         (done),
    .chunk_ptr    (chunk_ptr),
    .blk_addr     (blk_addr),
    .stage_lo     (stage_lo),
    .stage_hi     (stage_hi),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_addr  (mem_wr_addr),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr)
);

// File: tb/hw_align_buf_test.sv
// Directed bench for hw_align_buf: one task per scenario.
module hw_align_buf_test;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sw_wr_lo = 0, sw_wr_hi = 0;
    logic [31:0]   sw_wdata = '0;
    logic          start = 0, start_to_dev = 0, stop = 0;
    logic [AW-1:0] start_addr = '0;
    logic [31:0]   stage_lo, stage_hi;
    logic [1:0]    chunk_ptr;
    logic [AW-1:0] blk_addr;
    logic          busy, done;
    logic          in_valid = 0;
    logic [15:0]   in_data = '0;
    logic          out_valid;
    logic [15:0]   out_data;
    logic          out_ready = 0;
    logic          mem_wr_valid;
    logic [AW-1:0] mem_wr_addr;
    logic [63:0]   mem_wr_data;
    logic          mem_rd_req;
    logic [AW-1:0] mem_rd_addr;
    logic          mem_rd_valid = 0;
    logic [63:0]   mem_rd_data = '0;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    hw_align_buf #(.ADDR_W(AW)) uut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic sw_load(input logic [31:0] lo, input logic [31:0] hi);
        sw_wr_lo = 1; sw_wdata = lo; cyc(); sw_wr_lo = 0;
        sw_wr_hi = 1; sw_wdata = hi; cyc(); sw_wr_hi = 0;
    endtask

    task automatic do_start(input logic dir, input logic [AW-1:0] a);
        start = 1; start_to_dev = dir; start_addr = a; cyc(); start = 0;
    endtask

    task automatic push(input logic [15:0] d, input logic exp_wr,
                        input logic [AW-1:0] ea, input logic [63:0] ed);
        in_valid = 1; in_data = d; cyc(); in_valid = 0;
        chk("R4 write pulse", mem_wr_valid, exp_wr);
        if (exp_wr) begin
            chk("R1 write addr", mem_wr_addr, ea);
            chk("R4 write data", mem_wr_data, ed);
        end
    endtask

    task automatic pop(input logic [15:0] exp);
        chk("R7 out_valid", out_valid, 1);
        chk("R7 out_data", out_data, exp);
        out_ready = 1; cyc(); out_ready = 0;
    endtask

    task automatic do_stop();
        stop = 1; cyc(); stop = 0;
        chk("R6 busy low", busy, 0);
        chk("R6 done high", done, 1);
    endtask

    task automatic test_reset();
        chk("R2 reset stage", {stage_hi, stage_lo}, 0);
        chk("R3 reset ptr/busy/done", {chunk_ptr, busy, done}, 0);
        chk("R1 reset no mem", {mem_wr_valid, mem_rd_req, out_valid}, 0);
    endtask

    task automatic test_to_mem();
        sw_load(32'h2222_1111, 32'h4444_3333);
        chk("R2 stage readback", {stage_hi, stage_lo}, 64'h4444_3333_2222_1111);
        do_start(0, 32'h1004);
        chk("R3 ptr", chunk_ptr, 2);
        chk("R3 blk", blk_addr, 32'h1000);
        chk("R3 busy", busy, 1);
        sw_wr_lo = 1; sw_wdata = 32'hDEAD_BEEF; cyc(); sw_wr_lo = 0;
        chk("R9 sw write ignored", stage_lo, 32'h2222_1111);
        push(16'hA1A1, 0, 0, 0);
        push(16'hA2A2, 1, 32'h1000, 64'hA2A2_A1A1_2222_1111); // R5 head merge
        chk("R4 blk advance", blk_addr, 32'h1008);
        chk("R4 ptr wrap", chunk_ptr, 0);
        for (int i = 0; i < 8; i++)
            push(16'hB000 + 16'(i), (i % 4) == 3,
                 (i < 4) ? 32'h1008 : 32'h1010,
                 (i < 4) ? 64'hB003_B002_B001_B000 : 64'hB007_B006_B005_B004);
        push(16'hC000, 0, 0, 0);
        push(16'hC001, 0, 0, 0);
        push(16'hC002, 0, 0, 0);
        do_stop();
        chk("R6 residue count", chunk_ptr, 3);
        chk("R6 owed block", blk_addr, 32'h1018);
        chk("R6 tail lo", stage_lo, 32'hC001_C000);
        chk("R6 tail hi", stage_hi[15:0], 16'hC002);
        in_valid = 1; in_data = 16'h9999; cyc(); in_valid = 0;
        chk("R10 idle input ignored", {stage_hi[15:0], stage_lo}, 48'hC002_C001_C000);
        chk("R10 idle no write", mem_wr_valid, 0);
        cyc();
        chk("R6 hold ptr", chunk_ptr, 3);
        chk("R6 hold blk", blk_addr, 32'h1018);
    endtask

    task automatic test_to_dev_unaligned();
        sw_load(32'h1B1B_0A0A, 32'h3D3D_2C2C);
        do_start(1, 32'h2002);
        chk("R7 next boundary", blk_addr, 32'h2008);
        chk("R6 start clears done", done, 0);
        in_valid = 1; in_data = 16'hFFFF; cyc(); in_valid = 0;
        chk("R10 input ignored m2d", out_data, 16'h1B1B);
        chk("R10 no write m2d", mem_wr_valid, 0);
        pop(16'h1B1B);
        pop(16'h2C2C);
        pop(16'h3D3D);
        chk("R8 out_valid low", out_valid, 0);
        chk("R8 no early req", mem_rd_req, 0);
        cyc();
        chk("R8 read req", mem_rd_req, 1);
        chk("R8 read addr", mem_rd_addr, 32'h2008);
        cyc();
        chk("R8 single req", mem_rd_req, 0);
        mem_rd_valid = 1; mem_rd_data = 64'h7777_6666_5555_4444; cyc(); mem_rd_valid = 0;
        chk("R8 blk advance", blk_addr, 32'h2010);
        pop(16'h4444);
        pop(16'h5555);
        pop(16'h6666);
        pop(16'h7777);
        cyc();
        chk("R8 next req", mem_rd_req, 1);
        chk("R8 next addr", mem_rd_addr, 32'h2010);
        do_stop();
    endtask

    task automatic test_to_dev_aligned();
        do_start(1, 32'h3000);
        chk("R7 aligned blk", blk_addr, 32'h3000);
        chk("R7 aligned not ready", out_valid, 0);
        do_start(0, 32'h4444);
        chk("R9 start ignored", blk_addr, 32'h3000);
        chk("R7 fetch req", mem_rd_req, 1);
        chk("R7 fetch addr", mem_rd_addr, 32'h3000);
        cyc();
        mem_rd_valid = 1; mem_rd_data = 64'hDDDD_CCCC_BBBB_AAAA; cyc(); mem_rd_valid = 0;
        chk("R8 load blk", blk_addr, 32'h3008);
        pop(16'hAAAA);
        pop(16'hBBBB);
        do_stop();
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        test_reset();
        test_to_mem();
        test_to_dev_unaligned();
        test_to_dev_aligned();
        repeat (2) cyc();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule